// File: doc/BRIEF.md
# Checkpointed Register Rename Table

This block maps each architectural register onto the node that will produce its next value. It serves an out-of-order core that issues work in execution units: groups of nodes that the machine treats as one indivisible piece. Each unit owns one bank of the table. A bank records, for every register the unit writes, the dynamic tag of the latest writer and, once that result has appeared on the result bus, the value itself. Below all live banks sits a permanent register file that holds the committed architectural state.

One node issues per cycle. Its tag is made from the bank index and the node's slot within the bank. Its source register is resolved against the youngest live bank that writes it. If no live bank writes it, the permanent file answers. The answer is either a ready value or the tag to wait for.

When the oldest bank is closed and every one of its nodes has broadcast a result, the bank retires. Its values move into the permanent file, a commit pulse tells the memory side to make that unit's stores permanent, and the bank is freed for reuse in circular order. A misprediction flush names a live bank. That bank and every younger bank are discarded, which puts the table back in the state it had when that unit began.

Top module: `rename_bank_table`

## Requirements
- R1: After reset every register `r` reads as ready with value `r`, and `can_open` is 1.
- R2: The tag is `{bank, slot}`, with the bank index in the upper `$clog2(NBANK)` bits and the slot in the lower `$clog2(NSLOT)` bits. So tag = bank*NSLOT + slot. The first node of a unit takes the bank after the youngest live bank, at slot 0. Each later node of the same unit takes the next slot.
- R3: A source whose youngest writer has not yet broadcast reads as not ready (`src_rdy`=0), and `src_tag` carries that writer's tag.
- R4: A result on the bus (`bc_v`, `bc_tag`, `bc_val`) is forwarded to a lookup in the same cycle. It is also captured, so the register reads ready with that value in later cycles.
- R5: The youngest live bank that writes a register decides its lookup. Within one bank, the latest write to a register replaces earlier ones, so a result for an overwritten tag leaves the register pending.
- R6: Once the oldest bank is closed and all its nodes have broadcast, `commit_v` is 1 with `commit_bank` equal to that bank. At the next edge the bank's values enter the permanent file. Before that point no commit occurs.
- R7: Banks retire strictly oldest first. A finished younger bank waits for every older one to retire.
- R8: A flush of bank `b` discards `b` and all younger banks. Lookups then see the older state, and the next unit opens in bank `b`.
- R9: `can_open` is 0 exactly while all NBANK banks are live. Banks are reused circularly.
- R10: A flush suppresses any commit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_v | input | 1 | A node issues this cycle |
| iss_new | input | 1 | Node begins a new unit (opens a bank) |
| iss_last | input | 1 | Node ends its unit (closes the bank) |
| iss_dst_v | input | 1 | Node writes a register |
| iss_dst | input | $clog2(NREG) | Destination register |
| iss_src | input | $clog2(NREG) | Source register to look up (always active) |
| iss_tag | output | $clog2(NBANK)+$clog2(NSLOT) | Tag given to the issuing node |
| src_rdy | output | 1 | Source value is available |
| src_val | output | DW | Source value when ready |
| src_tag | output | $clog2(NBANK)+$clog2(NSLOT) | Tag to wait for when not ready |
| can_open | output | 1 | A free bank exists |
| bc_v | input | 1 | Result bus valid |
| bc_tag | input | $clog2(NBANK)+$clog2(NSLOT) | Result tag |
| bc_val | input | DW | Result value |
| flush_v | input | 1 | Roll back to the start of a unit |
| flush_bank | input | $clog2(NBANK) | Bank of the faulting unit |
| commit_v | output | 1 | Oldest bank retires; its stores become permanent |
| commit_bank | output | $clog2(NBANK) | Bank being retired |

## Verification
The bench builds the table with 8 registers, 4 banks, 4 slots per bank and 8-bit data, so every tag fits in 4 bits and a full ring of banks is reached after four units. These values make it possible to sweep every register at reset and to wrap the head and tail pointers past the last bank. They also allow filling the ring until `can_open` drops and flushing from the oldest, a middle and the open bank. Expected tags are computed as bank*4+slot from the order of opening.

// File: rtl/rename_bank_table.sv
module rename_bank_table #(
  parameter int NREG  = 8,
  parameter int NBANK = 4,
  parameter int NSLOT = 4,
  parameter int DW    = 8
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     iss_v,
  input  logic                                     iss_new,
  input  logic                                     iss_last,
  input  logic                                     iss_dst_v,
  input  logic [$clog2(NREG)-1:0]                  iss_dst,
  input  logic [$clog2(NREG)-1:0]                  iss_src,
  output logic [$clog2(NBANK)+$clog2(NSLOT)-1:0]   iss_tag,
  output logic                                     src_rdy,
  output logic [DW-1:0]                            src_val,
  output logic [$clog2(NBANK)+$clog2(NSLOT)-1:0]   src_tag,
  output logic                                     can_open,
  input  logic                                     bc_v,
  input  logic [$clog2(NBANK)+$clog2(NSLOT)-1:0]   bc_tag,
  input  logic [DW-1:0]                            bc_val,
  input  logic                                     flush_v,
  input  logic [$clog2(NBANK)-1:0]                 flush_bank,
  output logic                                     commit_v,
  output logic [$clog2(NBANK)-1:0]                 commit_bank
);
  localparam int RW = $clog2(NREG);
  localparam int BW = $clog2(NBANK);
  localparam int SW = $clog2(NSLOT);
  localparam int TW = BW + SW;

  logic [NREG-1:0] wr  [NBANK];
  logic [NREG-1:0] rdy [NBANK];
  logic [SW-1:0]   slt [NBANK][NREG];
  logic [DW-1:0]   val [NBANK][NREG];
  logic [DW-1:0]   perm [NREG];
  logic [SW:0]     cnt  [NBANK];
  logic [SW:0]     done [NBANK];
  logic [NBANK-1:0] closed, kill;
  logic [BW-1:0]   head, tail;
  logic [BW:0]     nact;
  logic            open;

  // lookup: walk oldest to youngest, last hit wins
  logic          hit;
  logic [BW-1:0] hb, bi;
  always_comb begin
    hit = 1'b0;
    hb  = '0;
    bi  = '0;
    for (int i = 0; i < NBANK; i++) begin
      bi = head + BW'(i);
      if ((BW+1)'(i) < nact && wr[bi][iss_src]) begin
        hit = 1'b1;
        hb  = bi;
      end
    end
  end

  wire [SW-1:0] hs = slt[hb][iss_src];
  wire          hr = rdy[hb][iss_src];
  assign src_tag = {hb, hs};
  assign src_rdy = !hit || hr || (bc_v && bc_tag == {hb, hs});
  assign src_val = !hit ? perm[iss_src] : hr ? val[hb][iss_src] : bc_val;

  wire [BW-1:0] ib    = iss_new ? tail : tail - 1'b1;
  wire [SW-1:0] islot = iss_new ? '0 : cnt[ib][SW-1:0];
  assign iss_tag  = {ib, islot};
  assign can_open = nact != (BW+1)'(NBANK);

  wire [BW-1:0] bb = bc_tag[TW-1:SW];
  wire [SW-1:0] bs = bc_tag[SW-1:0];

  wire ret_ok = nact != '0 && closed[head] && done[head] == cnt[head] &&
                ((rdy[head] | ~wr[head]) == '1);
  assign commit_v    = ret_ok && !flush_v;
  assign commit_bank = head;

  wire [BW-1:0] age = flush_bank - head;
  for (genvar g = 0; g < NBANK; g++) begin : g_kill
    wire [BW-1:0] rel = BW'(g) - head;
    assign kill[g] = flush_v && rel >= age && {1'b0, rel} < nact;
  end

  wire opening = iss_v && iss_new;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) perm[r] <= DW'(r);
      for (int b = 0; b < NBANK; b++) begin
        wr[b] <= '0; rdy[b] <= '0; cnt[b] <= '0; done[b] <= '0;
      end
      closed <= '0;
      head   <= '0;
      tail   <= '0;
      nact   <= '0;
      open   <= 1'b0;
    end else begin
      for (int b = 0; b < NBANK; b++)
        for (int r = 0; r < NREG; r++)
          if (bc_v && BW'(b) == bb && wr[b][r] && !rdy[b][r] && slt[b][r] == bs) begin
            rdy[b][r] <= 1'b1;
            val[b][r] <= bc_val;
          end
      if (bc_v) done[bb] <= done[bb] + 1'b1;

      if (flush_v) begin
        for (int b = 0; b < NBANK; b++)
          if (kill[b]) begin
            wr[b] <= '0; rdy[b] <= '0; cnt[b] <= '0; done[b] <= '0;
            closed[b] <= 1'b0;
          end
        tail <= flush_bank;
        nact <= {1'b0, age};
        open <= 1'b0;
      end else begin
        if (commit_v) begin
          for (int r = 0; r < NREG; r++)
            if (wr[head][r]) perm[r] <= val[head][r];
          wr[head] <= '0; rdy[head] <= '0; cnt[head] <= '0; done[head] <= '0;
          closed[head] <= 1'b0;
          head <= head + 1'b1;
        end
        if (iss_v) begin
          if (iss_new) begin
            if (open) closed[tail - 1'b1] <= 1'b1;
            tail      <= tail + 1'b1;
            open      <= 1'b1;
            cnt[tail] <= (SW+1)'(1);
          end else begin
            cnt[ib] <= cnt[ib] + 1'b1;
          end
          if (iss_dst_v) begin
            wr[ib][iss_dst]  <= 1'b1;
            rdy[ib][iss_dst] <= 1'b0;
            slt[ib][iss_dst] <= islot;
          end
          if (iss_last) begin
            closed[ib] <= 1'b1;
            open       <= 1'b0;
          end
        end
        nact <= nact + {{BW{1'b0}}, opening} - {{BW{1'b0}}, commit_v};
      end
    end
  end
endmodule

// File: rtl/rename_bank_table_chk.sv
module rename_bank_table_chk #(
  parameter int NBANK = 4,
  parameter int BW    = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          iss_v,
  input logic          iss_new,
  input logic          can_open,
  input logic          commit_v,
  input logic          flush_v,
  input logic [BW-1:0] flush_bank,
  input logic [BW-1:0] head,
  input logic [BW-1:0] tail,
  input logic [BW:0]   nact
);
  AST_NACT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) nact <= (BW+1)'(NBANK)); // R9
  AST_FULL_NO_OPEN: assert property (@(posedge clk) disable iff (!rst_n) !can_open |-> !(iss_v && iss_new)); // R9
  AST_COMMIT_HEAD: assert property (@(posedge clk) disable iff (!rst_n) commit_v |=> head == BW'($past(head) + 1'b1)); // R7
  AST_FLUSH_TAIL: assert property (@(posedge clk) disable iff (!rst_n) flush_v |=> tail == $past(flush_bank)); // R8
  AST_FLUSH_SHRINK: assert property (@(posedge clk) disable iff (!rst_n) flush_v |=> nact <= $past(nact)); // R8
endmodule

bind rename_bank_table rename_bank_table_chk #(.NBANK(NBANK), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .iss_v(iss_v), .iss_new(iss_new), .can_open(can_open),
  .commit_v(commit_v), .flush_v(flush_v), .flush_bank(flush_bank),
  .head(head), .tail(tail), .nact(nact)
);

// File: tb/sim_rename_bank_table.sv
module sim_rename_bank_table;
  localparam int NREG = 8, NBANK = 4, NSLOT = 4, DW = 8;
  localparam int RW = 3, BW = 2, TW = 4;

  logic clk = 0, rst_n = 0;
  logic iss_v = 0, iss_new = 0, iss_last = 0, iss_dst_v = 0;
  logic [RW-1:0] iss_dst = '0, iss_src = '0;
  logic [TW-1:0] iss_tag, src_tag, bc_tag = '0;
  logic src_rdy, can_open, bc_v = 0, flush_v = 0, commit_v;
  logic [DW-1:0] src_val, bc_val = '0;
  logic [BW-1:0] flush_bank = '0, commit_bank;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  rename_bank_table #(.NREG(NREG), .NBANK(NBANK), .NSLOT(NSLOT), .DW(DW)) u0 (.*);

  function automatic int tg(int b, int s);
    return b * NSLOT + s;
  endfunction

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic issue(bit nw, bit last, int dst, int exptag, string req);
    @(negedge clk);
    iss_v = 1; iss_new = nw; iss_last = last; iss_dst_v = 1; iss_dst = RW'(dst);
    #2 chk(req, int'(iss_tag), exptag);
    @(posedge clk); #1;
    iss_v = 0; iss_new = 0; iss_last = 0; iss_dst_v = 0;
  endtask

  task automatic bcast(int t, int v);
    @(negedge clk);
    bc_v = 1; bc_tag = TW'(t); bc_val = DW'(v);
    @(posedge clk); #1 bc_v = 0;
  endtask

  task automatic flush(int b);
    @(negedge clk);
    flush_v = 1; flush_bank = BW'(b);
    @(posedge clk); #1 flush_v = 0;
  endtask

  task automatic probe(int r, bit er, int ev, string req);
    iss_src = RW'(r);
    #2 chk({req, " rdy"}, int'(src_rdy), int'(er));
    if (er) chk({req, " val"}, int'(src_val), ev);
    else    chk({req, " tag"}, int'(src_tag), ev);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset sweep
    for (int r = 0; r < NREG; r++) probe(r, 1, r, "R1");
    chk("R1 can_open", int'(can_open), 1);

    // R2 tags in bank 0, R3 pending lookups
    issue(1, 0, 1, tg(0, 0), "R2 first");
    issue(0, 0, 2, tg(0, 1), "R2 slot1");
    issue(0, 1, 3, tg(0, 2), "R2 slot2");
    probe(1, 0, tg(0, 0), "R3 r1");
    probe(3, 0, tg(0, 2), "R3 r3");
    probe(0, 1, 0, "R3 untouched r0");

    // R4 forward then capture
    @(negedge clk);
    bc_v = 1; bc_tag = TW'(tg(0, 1)); bc_val = 8'h55; iss_src = 3'd2;
    #2 chk("R4 fwd rdy", int'(src_rdy), 1);
    chk("R4 fwd val", int'(src_val), 'h55);
    @(posedge clk); #1 bc_v = 0;
    probe(2, 1, 'h55, "R4 capture");

    // R5 youngest bank and latest write win
    issue(1, 0, 1, tg(1, 0), "R2 bank1");
    issue(0, 0, 1, tg(1, 1), "R5 rewrite");
    probe(1, 0, tg(1, 1), "R5 latest");
    bcast(tg(0, 0), 'h11);
    probe(1, 0, tg(1, 1), "R5 older result hidden");
    chk("R6 no early commit", int'(commit_v), 0);
    bcast(tg(1, 0), 'h99);
    probe(1, 0, tg(1, 1), "R5 overwritten tag");

    // R6 retire bank 0
    bcast(tg(0, 2), 'h33);
    #1 chk("R6 commit_v", int'(commit_v), 1);
    chk("R6 commit_bank", int'(commit_bank), 0);
    @(posedge clk); #1;
    chk("R6 commit done", int'(commit_v), 0);
    probe(3, 1, 'h33, "R6 perm r3");

    // R8 flush open bank 1
    flush(1);
    probe(1, 1, 'h11, "R8 rollback r1");
    chk("R8 can_open", int'(can_open), 1);
    issue(1, 0, 4, tg(1, 0), "R8 reuse bank");

    // R7 in-order retirement
    issue(0, 1, 5, tg(1, 1), "R2 bank1 slot1");
    issue(1, 1, 6, tg(2, 0), "R2 bank2");
    bcast(tg(2, 0), 'h66);
    #1 chk("R7 younger waits", int'(commit_v), 0);
    probe(6, 1, 'h66, "R4 r6");
    bcast(tg(1, 0), 'h44);
    bcast(tg(1, 1), 'h45);
    #1 chk("R7 first commit", int'(commit_v), 1);
    chk("R7 first bank", int'(commit_bank), 1);
    @(posedge clk); #1;
    chk("R7 second commit", int'(commit_v), 1);
    chk("R7 second bank", int'(commit_bank), 2);
    @(posedge clk); #1;
    chk("R7 idle", int'(commit_v), 0);
    probe(4, 1, 'h44, "R7 perm r4");
    probe(5, 1, 'h45, "R7 perm r5");
    probe(6, 1, 'h66, "R7 perm r6");

    // R9 fill ring with wrap: banks 3,0,1,2
    for (int k = 0; k < NBANK; k++) begin
      chk("R9 can_open before", int'(can_open), 1);
      issue(1, 0, 7, tg((3 + k) % NBANK, 0), "R9 circular");
    end
    chk("R9 full", int'(can_open), 0);
    probe(7, 0, tg(2, 0), "R5 youngest r7");

    // R8 middle flush keeps banks 3 and 0
    flush(1);
    probe(7, 0, tg(0, 0), "R8 middle");
    chk("R9 can_open after", int'(can_open), 1);
    issue(1, 0, 2, tg(1, 0), "R8 reopen");

    // R10 flush beats a ready commit
    bcast(tg(3, 0), 'h77);
    #1 chk("R10 ready", int'(commit_v), 1);
    chk("R10 bank", int'(commit_bank), 3);
    @(negedge clk);
    flush_v = 1; flush_bank = 2'd3;
    #2 chk("R10 suppressed", int'(commit_v), 0);
    @(posedge clk); #1 flush_v = 0;
    probe(7, 1, 7, "R8 all flushed");
    probe(2, 1, 'h55, "R8 all flushed r2");
    issue(1, 1, 0, tg(3, 0), "R8 open at flushed bank");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule